// File: doc/BRIEF.md
# Trace Resynchronization Interval Counter

This block tells a trace encoder when the next full synchronization packet is due. It keeps one counter whose unit is picked at run time by a two-bit mode: trace packets sent, clock cycles, or retired 16-bit instruction half-words. A second, four-bit field holds an exponent. The interval is two raised to that exponent plus a fixed offset of four. When the counter reaches that interval, the block raises a request flag. The flag stays up until the encoder reports that it has sent a sync packet.

The packet builder drives the event strobes and the acknowledge. The encoder reports on two lines: `sync_ack_i` is a sync packet sent in answer to the request, and `sync_other_i` is a sync packet sent for any other reason, such as trace start or an exception. Either one starts a new interval. Loading the mode or the exponent through `cfg_wr_i` also restarts the interval, so a new setting never inherits a half-finished count.

Top module: `resync_interval_ctr`

## Requirements
- R1: After reset `resync_req_o` is 0, and the mode and exponent take their parameter reset values (defaults: mode 2, exponent 0). With those defaults the request rises on the 16th rising edge after reset is released.
- R2: Mode 2 counts clock cycles. The request rises on exactly the 2^(exponent+4)-th rising edge after the interval restarts.
- R3: Mode 1 counts only cycles in which `pkt_sent_i` is 1. The request rises at the 2^(exponent+4)-th such cycle. Idle cycles and `hw_count_i` have no effect.
- R4: Mode 3 adds `hw_count_i` (0 to 7 half-words) to the counter each cycle. The request rises in the first cycle where the running total reaches or passes 2^(exponent+4). This includes the largest exponent, 15, which gives an interval of 2^19.
- R5: Once raised, the request stays at 1 while further events arrive, until a clear occurs.
- R6: A cycle with `sync_ack_i` or `sync_other_i` at 1 clears the counter and the request at that edge. An event in the same cycle is discarded.
- R7: Mode 0 holds the counter at zero and never raises the request, whatever events arrive.
- R8: A cycle with `cfg_wr_i` at 1 loads the mode (`cfg_mode_i`) and exponent (`cfg_limit_i`), and clears the counter and the request at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_wr_i | input | 1 | Load mode and exponent; restarts the interval |
| cfg_mode_i | input | 2 | Counting unit: 0 off, 1 packets, 2 cycles, 3 half-words |
| cfg_limit_i | input | LIM_W (4) | Interval exponent; interval is 2^(value+4) |
| pkt_sent_i | input | 1 | A trace packet was emitted this cycle |
| hw_count_i | input | HW_W (3) | Instruction half-words retired this cycle |
| sync_ack_i | input | 1 | Requested sync packet was sent |
| sync_other_i | input | 1 | A sync packet was sent for another reason |
| resync_req_o | output | 1 | Sync packet is due |

## Verification
The bench targets the exact edge on which the request rises in each mode. A comparison that is off by one, or uses greater-than where greater-or-equal is needed, would fire one edge late or early. Half-word counting is driven with steps that land exactly on the limit and steps that jump past it, including the 2^19 interval. A design that looks only for equality, or whose counter is too narrow, would never raise the request there. The bench also checks a clear that arrives mid-interval, a clear that arrives while the request is high, and a configuration write in the middle of a count. A design that keeps stale counts or lets the request stick would show a late or stuck flag. Mode 0 is run with every event strobe active, which exposes a counter that keeps running while off.

// File: rtl/resync_pkg.sv
package resync_pkg;

   // Counting unit selected by the two-bit mode field
   typedef enum logic [1:0] {
      RS_OFF = 2'd0,
      RS_PKT = 2'd1,
      RS_CYC = 2'd2,
      RS_HW  = 2'd3
   } rs_mode_e;

   // Fixed offset added to the programmed exponent
   localparam int unsigned RS_EXP_OFS = 4;

   // Counter width needed to hold the largest interval 2^(2^lim_w - 1 + ofs)
   function automatic int unsigned rs_cnt_width(input int unsigned lim_w,
                                                input int unsigned ofs);
      return (1 << lim_w) - 1 + ofs + 1;
   endfunction

endpackage

// File: rtl/resync_cfg_regs.sv
module resync_cfg_regs
   import resync_pkg::*;
#(
   parameter int unsigned LIM_W     = 4,
   parameter logic [3:0]  MODE_MASK = 4'b1111,
   parameter int unsigned RST_MODE  = 2,
   parameter int unsigned RST_LIMIT = 0,
   parameter bit          LIMIT_RW  = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             cfg_wr_i,
   input  logic [1:0]       cfg_mode_i,
   input  logic [LIM_W-1:0] cfg_limit_i,
   output rs_mode_e         mode_o,
   output logic [LIM_W-1:0] limit_o,
   output logic             cfg_clr_o
);

   localparam rs_mode_e       MODE_RST  = rs_mode_e'(RST_MODE[1:0]);
   localparam logic [LIM_W-1:0] LIMIT_RST = LIM_W'(RST_LIMIT);

   if (MODE_MASK[3:1] == 3'b000) begin : g_bad_mask
      $error("resync_cfg_regs: at least one non-zero mode must be supported");
   end
   if (MODE_MASK[RST_MODE[1:0]] == 1'b0) begin : g_bad_rst_mode
      $error("resync_cfg_regs: reset mode is not a supported mode");
   end
   if (RST_LIMIT >= (1 << LIM_W)) begin : g_bad_rst_limit
      $error("resync_cfg_regs: reset exponent does not fit the field");
   end

   rs_mode_e mode_q;
   logic     mode_ok;

   // write-any, read-legal: an unsupported code keeps the current mode
   assign mode_ok = MODE_MASK[cfg_mode_i];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         mode_q <= MODE_RST;
      end else if (cfg_wr_i && mode_ok) begin
         mode_q <= rs_mode_e'(cfg_mode_i);
      end
   end

   if (LIMIT_RW) begin : g_limit_rw
      logic [LIM_W-1:0] limit_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            limit_q <= LIMIT_RST;
         end else if (cfg_wr_i) begin
            limit_q <= cfg_limit_i;
         end
      end
      assign limit_o = limit_q;

      // R8
      limit_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         cfg_wr_i |=> (limit_o == $past(cfg_limit_i)));
   end else begin : g_limit_fixed
      assign limit_o = LIMIT_RST;
   end

   assign mode_o    = mode_q;
   assign cfg_clr_o = cfg_wr_i;

   // R8
   mode_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_wr_i && MODE_MASK[cfg_mode_i]) |=> (mode_o == rs_mode_e'($past(cfg_mode_i))));

endmodule

// File: rtl/resync_step_sel.sv
module resync_step_sel
   import resync_pkg::*;
#(
   parameter int unsigned HW_W  = 3,
   parameter int unsigned CNT_W = 20
) (
   input  rs_mode_e          mode_i,
   input  logic              pkt_sent_i,
   input  logic [HW_W-1:0]   hw_count_i,
   output logic [CNT_W-1:0]  step_o
);

   if (HW_W + 1 >= CNT_W) begin : g_bad_hw_w
      $error("resync_step_sel: half-word step too wide for the counter");
   end

   always_comb begin
      unique case (mode_i)
         RS_PKT:  step_o = CNT_W'(pkt_sent_i);
         RS_CYC:  step_o = CNT_W'(1);
         RS_HW:   step_o = CNT_W'(hw_count_i);
         default: step_o = '0;
      endcase
   end

endmodule

// File: rtl/resync_thresh.sv
module resync_thresh #(
   parameter int unsigned LIM_W = 4,
   parameter int unsigned OFS   = 4,
   parameter int unsigned CNT_W = 20
) (
   input  logic [LIM_W-1:0] limit_i,
   output logic [CNT_W-1:0] thresh_o
);

   localparam int unsigned MAX_EXP = (1 << LIM_W) - 1 + OFS;

   if (MAX_EXP >= CNT_W) begin : g_bad_cnt_w
      $error("resync_thresh: counter cannot hold the largest interval");
   end

   // one-hot decode of the exponent, one bit per possible interval
   for (genvar b = 0; b < CNT_W; b++) begin : g_bit
      if (b < OFS) begin : g_low
         assign thresh_o[b] = 1'b0;
      end else begin : g_dec
         assign thresh_o[b] = (limit_i == LIM_W'(b - OFS));
      end
   end

endmodule

// File: rtl/resync_counter.sv
module resync_counter
   import resync_pkg::*;
#(
   parameter int unsigned CNT_W = 20
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  rs_mode_e         mode_i,
   input  logic [CNT_W-1:0] step_i,
   input  logic [CNT_W-1:0] thresh_i,
   input  logic             sync_ack_i,
   input  logic             sync_other_i,
   input  logic             cfg_clr_i,
   output logic             req_o
);

   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             req_q, req_d;
   logic [CNT_W:0]   sum;
   logic             clr;
   logic             hit;

   assign clr = sync_ack_i | sync_other_i | cfg_clr_i;
   assign sum = {1'b0, cnt_q} + {1'b0, step_i};
   assign hit = (sum >= {1'b0, thresh_i});

   always_comb begin
      cnt_d = cnt_q;
      req_d = req_q;
      if (clr || (mode_i == RS_OFF)) begin
         cnt_d = '0;
         req_d = 1'b0;
      end else if (!req_q) begin
         if (hit) begin
            cnt_d = thresh_i;
            req_d = 1'b1;
         end else begin
            cnt_d = sum[CNT_W-1:0];
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
         req_q <= 1'b0;
      end else begin
         cnt_q <= cnt_d;
         req_q <= req_d;
      end
   end

   assign req_o = req_q;

   // R7
   off_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i == RS_OFF) |-> (cnt_q == '0 && !req_o));

   // R6
   sync_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sync_ack_i || sync_other_i) |=> (cnt_q == '0 && !req_o));

   // R8
   cfg_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_clr_i |=> (cnt_q == '0 && !req_o));

   // R5
   req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_o && !clr && mode_i != RS_OFF) |=> req_o);

   // R4
   cnt_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= thresh_i);

   // R2
   req_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(req_o) |-> (cnt_q == thresh_i));

   // R4
   thresh_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(thresh_i) && thresh_i != '0);

endmodule

// File: rtl/resync_interval_ctr.sv
module resync_interval_ctr
   import resync_pkg::*;
#(
   parameter int unsigned LIM_W     = 4,
   parameter int unsigned HW_W      = 3,
   parameter logic [3:0]  MODE_MASK = 4'b1111,
   parameter int unsigned RST_MODE  = 2,
   parameter int unsigned RST_LIMIT = 0,
   parameter bit          LIMIT_RW  = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             cfg_wr_i,
   input  logic [1:0]       cfg_mode_i,
   input  logic [LIM_W-1:0] cfg_limit_i,
   input  logic             pkt_sent_i,
   input  logic [HW_W-1:0]  hw_count_i,
   input  logic             sync_ack_i,
   input  logic             sync_other_i,
   output logic             resync_req_o
);

   localparam int unsigned CNT_W = rs_cnt_width(LIM_W, RS_EXP_OFS);

   rs_mode_e         mode;
   logic [LIM_W-1:0] limit;
   logic             cfg_clr;
   logic [CNT_W-1:0] step;
   logic [CNT_W-1:0] thresh;

   resync_cfg_regs #(
      .LIM_W     (LIM_W),
      .MODE_MASK (MODE_MASK),
      .RST_MODE  (RST_MODE),
      .RST_LIMIT (RST_LIMIT),
      .LIMIT_RW  (LIMIT_RW)
   ) u_cfg (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .cfg_wr_i    (cfg_wr_i),
      .cfg_mode_i  (cfg_mode_i),
      .cfg_limit_i (cfg_limit_i),
      .mode_o      (mode),
      .limit_o     (limit),
      .cfg_clr_o   (cfg_clr)
   );

   resync_step_sel #(
      .HW_W  (HW_W),
      .CNT_W (CNT_W)
   ) u_step (
      .mode_i     (mode),
      .pkt_sent_i (pkt_sent_i),
      .hw_count_i (hw_count_i),
      .step_o     (step)
   );

   resync_thresh #(
      .LIM_W (LIM_W),
      .OFS   (RS_EXP_OFS),
      .CNT_W (CNT_W)
   ) u_thresh (
      .limit_i  (limit),
      .thresh_o (thresh)
   );

   resync_counter #(
      .CNT_W (CNT_W)
   ) u_cnt (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .mode_i       (mode),
      .step_i       (step),
      .thresh_i     (thresh),
      .sync_ack_i   (sync_ack_i),
      .sync_other_i (sync_other_i),
      .cfg_clr_i    (cfg_clr),
      .req_o        (resync_req_o)
   );

endmodule

// File: tb/test_resync_interval_ctr.sv
`timescale 1ns/1ps
module test_resync_interval_ctr;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_wr = 1'b0;
   logic [1:0] cfg_mode = 2'd0;
   logic [3:0] cfg_limit = 4'd0;
   logic       pkt = 1'b0;
   logic [2:0] hw = 3'd0;
   logic       ack = 1'b0;
   logic       other = 1'b0;
   logic       req;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   resync_interval_ctr i_resync_interval_ctr (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .cfg_wr_i     (cfg_wr),
      .cfg_mode_i   (cfg_mode),
      .cfg_limit_i  (cfg_limit),
      .pkt_sent_i   (pkt),
      .hw_count_i   (hw),
      .sync_ack_i   (ack),
      .sync_other_i (other),
      .resync_req_o (req)
   );

   task automatic chk(input string tag, input logic exp);
      checks++;
      if (req !== exp) begin
         fails++;
         $display("FAIL %s: resync_req actual=%b expected=%b", tag, req, exp);
      end
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic cfg(input logic [1:0] m, input logic [3:0] l);
      cfg_mode = m; cfg_limit = l; cfg_wr = 1'b1;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic pulse_ack();
      ack = 1'b1; @(negedge clk); ack = 1'b0;
   endtask

   task automatic pulse_other();
      other = 1'b1; @(negedge clk); other = 1'b0;
   endtask

   task automatic t_reset();
      tick(3);
      rst_n = 1'b1;
      chk("R1 reset value", 1'b0);
      tick(15);
      chk("R1 default interval not yet reached", 1'b0);
      tick(1);
      chk("R1 default interval reached", 1'b1);
      pulse_ack();
      chk("R6 ack clears request", 1'b0);
   endtask

   task automatic t_cycles();
      cfg(2'd2, 4'd2);
      chk("R8 write clears", 1'b0);
      tick(63);
      chk("R2 cycle 63 of 64", 1'b0);
      tick(1);
      chk("R2 cycle 64 of 64", 1'b1);
      pkt = 1'b1; hw = 3'd7;
      tick(20);
      chk("R5 request held", 1'b1);
      pkt = 1'b0; hw = 3'd0;
      pulse_ack();
      chk("R6 ack clears", 1'b0);
   endtask

   task automatic t_packets();
      cfg(2'd1, 4'd1);
      hw = 3'd7;
      for (int i = 0; i < 31; i++) begin
         pkt = 1'b1; @(negedge clk);
         pkt = 1'b0; @(negedge clk);
      end
      chk("R3 31 packets of 32", 1'b0);
      tick(10);
      chk("R3 idle cycles ignored", 1'b0);
      pkt = 1'b1; @(negedge clk); pkt = 1'b0;
      chk("R3 32nd packet", 1'b1);
      pkt = 1'b1; tick(3); pkt = 1'b0;
      chk("R5 held under packets", 1'b1);
      hw = 3'd0;
      pulse_other();
      chk("R6 other sync clears", 1'b0);
   endtask

   task automatic t_halfwords();
      cfg(2'd3, 4'd0);
      pkt = 1'b1;
      hw = 3'd3; tick(5);
      chk("R4 total 15 of 16", 1'b0);
      hw = 3'd1; tick(1);
      chk("R4 total exactly 16", 1'b1);
      hw = 3'd0;
      cfg(2'd3, 4'd0);
      hw = 3'd7; tick(2);
      chk("R4 total 14 of 16", 1'b0);
      tick(1);
      chk("R4 overshoot to 21", 1'b1);
      hw = 3'd0; pkt = 1'b0;
      pulse_ack();
   endtask

   task automatic t_hw_max();
      cfg(2'd3, 4'd15);
      hw = 3'd7;
      tick(74898);
      chk("R4 max interval 524286 of 524288", 1'b0);
      tick(1);
      chk("R4 max interval passed", 1'b1);
      hw = 3'd0;
      pulse_ack();
      chk("R6 ack after max interval", 1'b0);
   endtask

   task automatic t_off();
      cfg(2'd0, 4'd0);
      pkt = 1'b1; hw = 3'd7;
      tick(200);
      chk("R7 off mode never requests", 1'b0);
      pkt = 1'b0; hw = 3'd0;
   endtask

   task automatic t_clears();
      cfg(2'd2, 4'd0);
      tick(10);
      pulse_other();
      tick(15);
      chk("R6 restart after other sync", 1'b0);
      tick(1);
      chk("R6 full interval after other sync", 1'b1);
      pulse_ack();
      tick(15);
      chk("R6 ack-cycle event discarded", 1'b0);
      tick(1);
      chk("R6 full interval after ack", 1'b1);
      pulse_ack();
   endtask

   task automatic t_cfg_mid();
      cfg(2'd2, 4'd0);
      tick(12);
      cfg(2'd2, 4'd0);
      tick(15);
      chk("R8 mid-count write restarts", 1'b0);
      tick(1);
      chk("R8 interval after restart", 1'b1);
      cfg(2'd2, 4'd1);
      chk("R8 write clears request", 1'b0);
      tick(31);
      chk("R8 new exponent 31 of 32", 1'b0);
      tick(1);
      chk("R8 new exponent 32 of 32", 1'b1);
   endtask

   initial begin
      t_reset();
      t_cycles();
      t_packets();
      t_halfwords();
      t_hw_max();
      t_off();
      t_clears();
      t_cfg_mid();
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule